// File: doc/BRIEF.md
# Interrupt State, Enable and Test Register Bank

This block holds the interrupt bookkeeping of a peripheral as one or more register groups. Each group has a sticky state register that hardware event inputs set and software clears by writing ones, an enable register, and a write-only test register. A write to the test register forces bits into state so that software can raise any interrupt without the hardware condition that normally causes it. Every state bit drives one interrupt output through its enable bit.

Groups differ in width. The width of each group comes from a packed parameter, one byte per group, with group 0 in the low byte. Event inputs and interrupt outputs of all groups are packed side by side. The register port is a plain synchronous one. Group k takes word addresses 4k to 4k+3, and the low two address bits select the register inside the group.

Top module: `irq_bank`

## Requirements
- R1: After reset, every state and enable bit is zero, and irq_o is all zero.
- R2: An event bit high for one cycle sets its state bit on that clock edge, and the bit stays set.
- R3: A write to a state register (address bits [1:0] = 0) clears exactly the bits written as 1 and leaves the others unchanged.
- R4: A write to a test register (address bits [1:0] = 2) ORs the written bits into state and never clears a state bit, even when it writes zero.
- R5: A test register always reads as zero.
- R6: Each irq_o bit equals its state bit ANDed with its enable bit (address bits [1:0] = 1, read/write), with no added cycle after the state or enable flop changes.
- R7: A state bit stays set through enable changes and test writes until a write of 1 to it in the state register.
- R8: The event and irq bits of group k start at the sum of the widths of groups 0 to k-1, and the registers of group k sit at word address 4k + select.
- R9: Only the low W bits of a group's registers exist: upper written bits are dropped, and they read as zero.
- R10: When an event and a write-1-to-clear hit the same state bit in the same cycle, the bit ends up set.
- R11: A test write and an event in the same cycle both set their bits.
- R12: rdata_o carries the addressed value in the cycle after re_i. Select 3 and group numbers at or above the group count read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Word address: group in [AW-1:2], select in [1:0] |
| we_i | input | 1 | Write strobe |
| wdata_i | input | DW | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | DW | Read data, registered |
| event_i | input | TOT | Hardware event bits of all groups, packed |
| irq_o | output | TOT | Interrupt outputs of all groups, packed |

## Verification
The bench builds the bank with three groups of widths 5, 3 and 6 and a 16-bit data path. The irq bits therefore start at offsets 0, 5 and 8, and the uneven widths check the packing rule against a non-trivial offset sum. The narrow groups leave unused upper bits in every data word, which makes write masking and zero read-back observable. Six address bits allow group numbers above the last real group, so decoding of unmapped groups is also exercised.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  localparam int unsigned MAX_GRP = 16;

  typedef enum logic [1:0] {
    SEL_STATE  = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_TEST   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // one byte per group, group 0 in the low byte
  typedef logic [MAX_GRP*8-1:0] grp_widths_t;

  function automatic int unsigned grp_width(grp_widths_t w, int unsigned k);
    return 32'(w[k*8 +: 8]);
  endfunction

  function automatic int unsigned grp_offset(grp_widths_t w, int unsigned k);
    int unsigned s;
    s = 0;
    for (int unsigned j = 0; j < k; j++) s += grp_width(w, j);
    return s;
  endfunction

  function automatic int unsigned grp_max(grp_widths_t w, int unsigned n);
    int unsigned m;
    m = 0;
    for (int unsigned j = 0; j < n; j++) if (grp_width(w, j) > m) m = grp_width(w, j);
    return m;
  endfunction

endpackage

// File: rtl/irq_grp.sv
module irq_grp #(
  parameter int unsigned W  = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  event_i,
  input  logic          clr_we_i,
  input  logic          en_we_i,
  input  logic          test_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [W-1:0]  state_o,
  output logic [W-1:0]  enable_o,
  output logic [W-1:0]  irq_o
);

  logic [W-1:0] state_q, state_d;
  logic [W-1:0] en_q;
  logic [W-1:0] wbits, set_bits, clr_bits;
  logic         unused_wdata;

  assign wbits        = wdata_i[W-1:0];
  assign unused_wdata = ^wdata_i;

  assign set_bits = event_i | (test_we_i ? wbits : '0);
  assign clr_bits = clr_we_i ? wbits : '0;
  // set after clear: a coincident event survives
  assign state_d  = (state_q & ~clr_bits) | set_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      en_q    <= '0;
    end else begin
      state_q <= state_d;
      if (en_we_i) en_q <= wbits;
    end
  end

  assign state_o  = state_q;
  assign enable_o = en_q;
  assign irq_o    = state_q & en_q;

endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux #(
  parameter int unsigned DW      = 32,
  parameter int unsigned NUM_GRP = 2,
  parameter int unsigned GSEL_W  = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           re_i,
  input  logic [GSEL_W-1:0]              grp_i,
  input  irq_bank_pkg::reg_sel_e         sel_i,
  input  logic [NUM_GRP-1:0][DW-1:0]     st_words_i,
  input  logic [NUM_GRP-1:0][DW-1:0]     en_words_i,
  output logic [DW-1:0]                  rdata_o
);

  logic [DW-1:0] rd_d, rd_q;

  always_comb begin
    rd_d = '0;
    for (int k = 0; k < NUM_GRP; k++) begin
      if (grp_i == GSEL_W'(k)) begin
        unique case (sel_i)
          irq_bank_pkg::SEL_STATE:  rd_d = st_words_i[k];
          irq_bank_pkg::SEL_ENABLE: rd_d = en_words_i[k];
          default:                  rd_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (re_i) rd_q <= rd_d;
  end

  assign rdata_o = rd_q;

endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int unsigned DW      = 32,
  parameter int unsigned AW      = 6,
  parameter int unsigned NUM_GRP = 2,
  parameter logic [NUM_GRP*8-1:0] GRP_W = 16'h0305,
  localparam irq_bank_pkg::grp_widths_t WX = irq_bank_pkg::grp_widths_t'(GRP_W),
  localparam int unsigned TOT = irq_bank_pkg::grp_offset(WX, NUM_GRP)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  addr_i,
  input  logic           we_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           re_i,
  output logic [DW-1:0]  rdata_o,
  input  logic [TOT-1:0] event_i,
  output logic [TOT-1:0] irq_o
);

  localparam int unsigned GSEL_W = AW - 2;
  localparam int unsigned MAXW   = irq_bank_pkg::grp_max(WX, NUM_GRP);

  logic [GSEL_W-1:0]          grp_sel;
  irq_bank_pkg::reg_sel_e     reg_sel;
  logic [NUM_GRP-1:0][DW-1:0] st_words, en_words;
  logic [TOT-1:0]             state_all, en_all;

  assign grp_sel = addr_i[AW-1:2];
  assign reg_sel = irq_bank_pkg::reg_sel_e'(addr_i[1:0]);

  for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
    localparam int unsigned W   = irq_bank_pkg::grp_width(WX, k);
    localparam int unsigned OFF = irq_bank_pkg::grp_offset(WX, k);

    logic         hit;
    logic [W-1:0] st, en, irq;

    assign hit = we_i && (grp_sel == GSEL_W'(k));

    irq_grp #(.W(W), .DW(DW)) u_grp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .event_i   (event_i[OFF +: W]),
      .clr_we_i  (hit && (reg_sel == irq_bank_pkg::SEL_STATE)),
      .en_we_i   (hit && (reg_sel == irq_bank_pkg::SEL_ENABLE)),
      .test_we_i (hit && (reg_sel == irq_bank_pkg::SEL_TEST)),
      .wdata_i   (wdata_i),
      .state_o   (st),
      .enable_o  (en),
      .irq_o     (irq)
    );

    always_comb begin
      st_words[k]      = '0;
      en_words[k]      = '0;
      st_words[k][W-1:0] = st;
      en_words[k][W-1:0] = en;
    end

    assign state_all[OFF +: W] = st;
    assign en_all[OFF +: W]    = en;
    assign irq_o[OFF +: W]     = irq;
  end

  irq_rd_mux #(.DW(DW), .NUM_GRP(NUM_GRP), .GSEL_W(GSEL_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .re_i       (re_i),
    .grp_i      (grp_sel),
    .sel_i      (reg_sel),
    .st_words_i (st_words),
    .en_words_i (en_words),
    .rdata_o    (rdata_o)
  );

endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 6,
  parameter int unsigned TOT  = 8,
  parameter int unsigned MAXW = 5
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [AW-1:0]  addr_i,
  input logic           we_i,
  input logic           re_i,
  input logic [DW-1:0]  rdata_o,
  input logic [TOT-1:0] event_i,
  input logic [TOT-1:0] irq_o,
  input logic [TOT-1:0] state_all,
  input logic [TOT-1:0] en_all
);

  AST_EVENT_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((state_all & $past(event_i)) == $past(event_i))); // R10

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_all & ~$past(state_all) & ~$past(event_i)) != '0) |-> $past(we_i)); // R4

  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(state_all) & ~state_all) != '0) |-> $past(we_i)); // R7

  AST_GATED_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~en_all) == '0) && ((irq_o & ~state_all) == '0)); // R6

  AST_TEST_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i[1]) |=> (rdata_o == '0)); // R5

  if (MAXW < DW) begin : g_hi
    AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rdata_o[DW-1:MAXW] == '0); // R9
  end

endmodule

bind irq_bank irq_bank_chk #(.DW(DW), .AW(AW), .TOT(TOT), .MAXW(MAXW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .re_i      (re_i),
  .rdata_o   (rdata_o),
  .event_i   (event_i),
  .irq_o     (irq_o),
  .state_all (state_all),
  .en_all    (en_all)
);

// File: tb/sim_irq_bank.sv
module sim_irq_bank;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int NG = 3;
  localparam int TOT = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          re = 1'b0;
  logic [DW-1:0] rdata;
  logic [TOT-1:0] ev = '0;
  logic [TOT-1:0] irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int unsigned gw [NG]   = '{5, 3, 6};
  int unsigned goff [NG] = '{0, 5, 8};
  logic [DW-1:0] m_st [NG];
  logic [DW-1:0] m_en [NG];

  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_bank #(.DW(DW), .AW(AW), .NUM_GRP(NG), .GRP_W(24'h060305)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata), .event_i(ev), .irq_o(irq)
  );

  function automatic logic [DW-1:0] msk(int g);
    return DW'((32'd1 << gw[g]) - 1);
  endfunction

  function automatic logic [TOT-1:0] exp_irq();
    logic [TOT-1:0] r;
    r = '0;
    for (int g = 0; g < NG; g++)
      for (int b = 0; b < int'(gw[g]); b++)
        r[goff[g] + b] = m_st[g][b] & m_en[g][b];
    return r;
  endfunction

  function automatic void compare(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endfunction

  // driver: one cycle of register write and/or events, model updated alongside
  task automatic op(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d,
                    input logic [TOT-1:0] e);
    int g;
    @(negedge clk);
    addr = a; we = w; wdata = d; ev = e;
    g = int'(a[AW-1:2]);
    if (w && g < NG) begin
      case (a[1:0])
        2'd0: m_st[g] &= ~(d & msk(g));
        2'd1: m_en[g] = d & msk(g);
        2'd2: m_st[g] |= d & msk(g);
        default: ;
      endcase
    end
    for (int k = 0; k < NG; k++)
      for (int b = 0; b < int'(gw[k]); b++)
        if (e[goff[k] + b]) m_st[k][b] = 1'b1;
    @(negedge clk);
    we = 1'b0; ev = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    addr = a; re = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    re = 1'b0;
  endtask

  // monitor: a read accepted on a rising edge is compared at the following falling edge
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && re) begin
        @(negedge clk);
        if (exp_q.size() == 0) compare("R12 unexpected read", 32'(rdata), 32'hDEAD);
        else compare(tag_q.pop_front(), 32'(rdata), 32'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    for (int i = 0; i < 200000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < NG; g++) begin m_st[g] = '0; m_en[g] = '0; end
    repeat (3) @(negedge clk);
    compare("R1 irq in reset", 32'(irq), 32'(0));
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 irq after reset", 32'(irq), 32'(0));
    for (int g = 0; g < NG; g++) begin
      rd(AW'(g*4 + 0), 16'h0, "R1 state reset");
      rd(AW'(g*4 + 1), 16'h0, "R1 enable reset");
    end

    // R2: events set sticky state, no output while disabled
    op('0, 1'b0, '0, 14'b000001_000_10010);
    rd(6'd0, m_st[0], "R2 state g0 after event");
    compare("R6 irq disabled", 32'(irq), 32'(exp_irq()));

    // R9: enable masking, R6 output follows
    op(6'd1, 1'b1, 16'hFFFF, '0);
    rd(6'd1, 16'h001F, "R9 enable g0 upper dropped");
    compare("R6 irq enabled g0", 32'(irq), 32'(exp_irq()));

    // R4 / R5: test injection on group 1
    op(6'd6, 1'b1, 16'hFFF5, '0);
    rd(6'd4, 16'h0005, "R4 state g1 test set");
    rd(6'd6, 16'h0000, "R5 test reads zero");
    op(6'd6, 1'b1, 16'h0000, '0);
    rd(6'd4, 16'h0005, "R4 zero test write keeps state");

    // R3: partial clear
    op(6'd0, 1'b1, 16'hFFF2, '0);
    rd(6'd0, m_st[0], "R3 w1c partial");
    compare("R3 state g0 value", 32'(m_st[0]), 32'h0);

    // R7: enable toggling keeps state
    op(6'd5, 1'b1, 16'h0000, '0);
    op(6'd5, 1'b1, 16'h0007, '0);
    rd(6'd4, 16'h0005, "R7 state survives enable change");
    compare("R7 irq g1 re-enabled", 32'(irq), 32'(exp_irq()));

    // R10: event and clear on the same bit
    op(6'd0, 1'b1, 16'h0001, 14'h0001);
    rd(6'd0, 16'h0001, "R10 set wins over clear");

    // R11: test write and event together
    op(6'd2, 1'b1, 16'h0004, 14'h0008);
    rd(6'd0, 16'h000D, "R11 test and event OR");

    // R8: group 2 at offset 8, address 8..10
    op(6'd9, 1'b1, 16'h003F, '0);
    op(6'd10, 1'b1, 16'h0021, '0);
    rd(6'd8, 16'h0021, "R8 state g2");
    compare("R8 irq packing", 32'(irq), 32'(exp_irq()));
    compare("R8 irq g2 bits", 32'(irq[13:8]), 32'h21);

    // R12: unmapped select and group
    op(6'd3, 1'b1, 16'hFFFF, '0);
    op(6'd13, 1'b1, 16'hFFFF, '0);
    compare("R12 unmapped write no effect", 32'(irq), 32'(exp_irq()));
    rd(6'd3, 16'h0000, "R12 select 3 reads zero");
    rd(6'd12, 16'h0000, "R12 group 3 reads zero");
    rd(6'd9, 16'h003F, "R12 read latency enable g2");

    // clear everything
    op(6'd0, 1'b1, 16'hFFFF, '0);
    op(6'd4, 1'b1, 16'hFFFF, '0);
    op(6'd8, 1'b1, 16'hFFFF, '0);
    compare("R3 all cleared irq", 32'(irq), 32'(0));

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) compare("R12 reads pending", 32'(exp_q.size()), 32'(0));
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule